// File: doc/BRIEF.md
# Freezable Event Counter Bank

This block is a bank of performance counters reached through a plain 32-bit register port. Counter 0 is a 64-bit cycle counter. Each of the remaining counters is 32 bits wide. It picks one line of a shared event input bus through a 7-bit select code and advances by one in every cycle in which that line is high. Code 0 makes a counter count every cycle.

Counting is gated at two levels. A global control word holds a freeze-all bit, an interrupt enable and a freeze-on-condition enable. Each counter's own control word holds a local freeze bit, a condition enable and the event select. The global freeze takes priority over the local freezes.

A counter's most significant bit can rise from 0 to 1 while the global interrupt enable, the global freeze-on-condition enable and that counter's condition enable are all 1. When that happens the hardware sets the global freeze bit, so every counter stops, and the interrupt output goes high. The interrupt stays high until software has cleared the top bit of every condition-enabled counter and has cleared the global freeze bit.

Top module: `pmon_bank`

## Requirements
- R1: While reset is high and after it, all control words and count values are zero and `irq_o` is low.
- R2: The global control word sits at byte address 0x40. Bit 31 is freeze-all, bit 30 is the interrupt enable and bit 29 is the freeze-on-condition enable. Its other bits read as zero.
- R3: Counter n's control word sits at 0x50+0x10*n. Bit 31 is the local freeze, bit 26 is the condition enable and bits [22:16] are the event select. Other bits read as zero. The word at 0x54+0x10*n reads as zero and ignores writes.
- R4: Counter 0 is 64 bits wide and counts every cycle while it is not frozen. Its low word is at 0x58 and its high word at 0x5C, and the carry passes from the low word into the high word.
- R5: Counter n (n>=1), at 0x58+0x10*n, advances by one on each clock edge where its selected bit of `evt_i` is high. Select code 0 advances it on every edge.
- R6: A set local freeze bit stops only its own counter.
- R7: While the global freeze bit is set, no counter changes except by a register write.
- R8: A write to a count word loads the written value, so writing 0 clears it. The two words of counter 0 are written separately. A write takes precedence over an increment in the same cycle.
- R9: When a counter's top bit rises from 0 to 1 on an increment with all three enables at 1, the global freeze bit and `irq_o` are both 1 after that edge. If any of the three enables is 0, neither is set.
- R10: `irq_o` stays high until no condition-enabled counter has its top bit set and the global freeze bit is 0. It drops one edge after both conditions hold.
- R11: When a hardware freeze and a software write of the global word fall on the same edge, the freeze-all bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (8) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 128 | Event lines shared by the event counters |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
Two things can land on the same clock edge: the hardware sets the freeze bit because of an overflow, and software writes the global control word. The bench preloads a condition-enabled counter two counts below its top bit, releases the freeze and schedules a second write of the global word, with freeze-all clear, to land exactly on the edge where the top bit rises. It then expects the read-back global word to show freeze-all set and the interrupt high. A count write that lands on an incrementing edge is judged the same way: the written value must win, and counting resumes from that value on the next edge.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int DATA_W  = 32;
    localparam int CYC_W   = 64;
    localparam int SEL_W   = 7;

    localparam int G_FRZ_B = 31;
    localparam int G_IE_B  = 30;
    localparam int G_CFE_B = 29;
    localparam int L_FRZ_B = 31;
    localparam int L_CE_B  = 26;
    localparam int L_SEL_B = 16;

    localparam int GCTL_OFS = 'h40;
    localparam int BANK_OFS = 'h50;
    localparam int STRIDE   = 'h10;

    typedef struct packed {
        logic             frz;
        logic             ce;
        logic [SEL_W-1:0] sel;
    } lctl_t;

    function automatic int ctla_ofs(input int n);
        return BANK_OFS + STRIDE * n;
    endfunction

    function automatic int cnt_ofs(input int n);
        return BANK_OFS + STRIDE * n + 8;
    endfunction

    function automatic logic [DATA_W-1:0] lctl_pack(input lctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[L_FRZ_B] = c.frz;
        w[L_CE_B] = c.ce;
        w[L_SEL_B +: SEL_W] = c.sel;
        return w;
    endfunction

    function automatic lctl_t lctl_unpack(input logic [DATA_W-1:0] w);
        lctl_t c;
        c.frz = w[L_FRZ_B];
        c.ce  = w[L_CE_B];
        c.sel = w[L_SEL_B +: SEL_W];
        return c;
    endfunction

endpackage

// File: rtl/pmon_counter.sv
module pmon_counter
    import pmon_pkg::*;
#(
    parameter int W  = 32,
    parameter int NW = W / DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic [NW-1:0]     wr_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [W-1:0]      val,
    output logic              rise
);

    localparam logic [W-1:0] EDGE_VAL = {1'b0, {(W-1){1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else if (|wr_word) begin
            for (int w = 0; w < NW; w++) begin
                if (wr_word[w]) val[w*DATA_W +: DATA_W] <= wdata;
            end
        end else if (inc) begin
            val <= val + 1'b1;
        end
    end

    assign rise = inc && !(|wr_word) && (val == EDGE_VAL);

    p_msb_set_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> val[W-1]);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!inc && !(|wr_word)) |=> $stable(val));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        wr_word[0] |=> (val[DATA_W-1:0] == $past(wdata)));

endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 11,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [(1<<SEL_W)-1:0]    evt_i,
    output logic                     irq_o
);

    localparam int EVT_NUM = 1 << SEL_W;

    logic                gfrz, gie, gfce;
    lctl_t               lctl [NUM_CNT];
    logic [DATA_W-1:0]   cnt_lo [NUM_CNT];
    logic [DATA_W-1:0]   cnt0_hi;
    logic [NUM_CNT-1:0]  msb, rise, ce_vec;
    logic                trip, ovf_live, irq_q;

    // local control words
    always_ff @(posedge clk) begin
        for (int n = 0; n < NUM_CNT; n++) begin
            if (rst) lctl[n] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(ctla_ofs(n)))
                lctl[n] <= lctl_unpack(reg_wdata);
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_CNT; n++) ce_vec[n] = lctl[n].ce;
    end

    assign trip     = gie && gfce && |(rise & ce_vec);
    assign ovf_live = |(msb & ce_vec);

    // global control: hardware freeze overrides a same-edge software write
    always_ff @(posedge clk) begin
        if (rst) begin
            gfrz <= 1'b0;
            gie  <= 1'b0;
            gfce <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(GCTL_OFS)) begin
                gfrz <= reg_wdata[G_FRZ_B];
                gie  <= reg_wdata[G_IE_B];
                gfce <= reg_wdata[G_CFE_B];
            end
            if (trip) gfrz <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     irq_q <= 1'b0;
        else if (trip)               irq_q <= 1'b1;
        else if (!gfrz && !ovf_live) irq_q <= 1'b0;
    end
    assign irq_o = irq_q;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        if (n == 0) begin : g_cyc
            logic [CYC_W-1:0]        v;
            logic [CYC_W/DATA_W-1:0] ww;
            logic                    run;
            always_comb begin
                for (int w = 0; w < CYC_W/DATA_W; w++)
                    ww[w] = reg_wr && reg_addr == ADDR_W'(cnt_ofs(0) + 4*w);
            end
            assign run = !gfrz && !lctl[0].frz;
            pmon_counter #(.W(CYC_W)) u_ctr (
                .clk(clk), .rst(rst), .inc(run), .wr_word(ww),
                .wdata(reg_wdata), .val(v), .rise(rise[0])
            );
            assign cnt_lo[0] = v[DATA_W-1:0];
            assign cnt0_hi   = v[CYC_W-1 -: DATA_W];
            assign msb[0]    = v[CYC_W-1];
        end else begin : g_evt
            logic [DATA_W-1:0] v;
            logic [0:0]        ww;
            logic              hit, run;
            assign hit = (lctl[n].sel == '0) || evt_i[lctl[n].sel];
            assign run = !gfrz && !lctl[n].frz && hit;
            assign ww[0] = reg_wr && reg_addr == ADDR_W'(cnt_ofs(n));
            pmon_counter #(.W(DATA_W)) u_ctr (
                .clk(clk), .rst(rst), .inc(run), .wr_word(ww),
                .wdata(reg_wdata), .val(v), .rise(rise[n])
            );
            assign cnt_lo[n] = v;
            assign msb[n]    = v[DATA_W-1];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(GCTL_OFS)) begin
            reg_rdata[G_FRZ_B] = gfrz;
            reg_rdata[G_IE_B]  = gie;
            reg_rdata[G_CFE_B] = gfce;
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr == ADDR_W'(ctla_ofs(n))) reg_rdata = lctl_pack(lctl[n]);
            if (reg_addr == ADDR_W'(cnt_ofs(n)))  reg_rdata = cnt_lo[n];
        end
        if (reg_addr == ADDR_W'(cnt_ofs(0) + 4)) reg_rdata = cnt0_hi;
    end

    p_trip_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        trip |=> gfrz);

    p_trip_irq_r9: assert property (@(posedge clk) disable iff (rst)
        trip |=> irq_o);

    p_irq_held_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_o && gfrz) |=> irq_o);

    p_global_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (gfrz && !reg_wr) |=> $stable(cnt_lo[1]));

    initial assert (EVT_NUM == 128 && NUM_CNT >= 2);

endmodule

// File: tb/pmon_bank_bench.sv
`timescale 1ns/1ps
module pmon_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [127:0] evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    pmon_bank u_pmon_bank (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
    );

    localparam logic [7:0]  GA  = 8'h40;
    localparam logic [31:0] FRZ = 32'h8000_0000;

    function automatic logic [7:0] a_ctl(input int n);
        return 8'(8'h50 + 16 * n);
    endfunction
    function automatic logic [7:0] a_cnt(input int n);
        return 8'(8'h58 + 16 * n);
    endfunction
    function automatic logic [31:0] lw(input bit frz, input bit ce, input int sel);
        return (32'(frz) << 31) | (32'(ce) << 26) | (32'(sel & 127) << 16);
    endfunction

    // called right after a falling edge: lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {sel[54:48], drive[47], bit[46:40], cycles[39:32], expected[31:0]}
    localparam int NV = 6;
    localparam logic [54:0] VEC [NV] = '{
        {7'd0,   1'b0, 7'd0,   8'd5,  32'd5},
        {7'd5,   1'b1, 7'd5,   8'd7,  32'd7},
        {7'd5,   1'b1, 7'd6,   8'd7,  32'd0},
        {7'd127, 1'b1, 7'd127, 8'd3,  32'd3},
        {7'd64,  1'b1, 7'd64,  8'd10, 32'd10},
        {7'd1,   1'b0, 7'd0,   8'd4,  32'd0}
    };

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        rd(GA, rv);          chk("R1 global", rv, 32'h0);
        rd(a_ctl(1), rv);    chk("R1 local", rv, 32'h0);
        rd(a_cnt(1), rv);    chk("R1 count", rv, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        wr(GA, FRZ);

        // R5: event selection table on counter 1
        for (int i = 0; i < NV; i++) begin
            wr(a_ctl(1), lw(0, 0, int'(VEC[i][54:48])));
            wr(a_cnt(1), 32'h0);
            evt_i = '0;
            if (VEC[i][47]) evt_i[VEC[i][46:40]] = 1'b1;
            wr(GA, 32'h0);
            repeat (int'(VEC[i][39:32]) - 1) @(negedge clk);
            wr(GA, FRZ);
            evt_i = '0;
            rd(a_cnt(1), rv);
            chk($sformatf("R5 vector %0d", i), rv, VEC[i][31:0]);
        end

        // R2: global word read-back
        wr(GA, 32'hFFFF_FFFF);
        rd(GA, rv); chk("R2 global fields", rv, 32'hE000_0000);
        wr(GA, FRZ);

        // R3: local word fields and the empty neighbour word
        wr(a_ctl(7), 32'hFFFF_FFFF);
        rd(a_ctl(7), rv); chk("R3 local fields", rv, 32'h847F_0000);
        wr(a_ctl(7) + 8'h4, 32'hFFFF_FFFF);
        rd(a_ctl(7) + 8'h4, rv); chk("R3 second word", rv, 32'h0);
        wr(a_ctl(7), 32'h0);

        // R4: 64-bit carry
        wr(a_cnt(0) + 8'h4, 32'h0);
        wr(a_cnt(0), 32'hFFFF_FFFE);
        wr(GA, 32'h0);
        repeat (2) @(negedge clk);
        wr(GA, FRZ);
        rd(a_cnt(0), rv);         chk("R4 low word", rv, 32'h1);
        rd(a_cnt(0) + 8'h4, rv);  chk("R4 high word", rv, 32'h1);

        // R6: local freeze on counter 1 only
        wr(a_ctl(1), lw(1, 0, 0));
        wr(a_ctl(2), lw(0, 0, 0));
        wr(a_cnt(1), 32'h0);
        wr(a_cnt(2), 32'h0);
        wr(GA, 32'h0);
        repeat (3) @(negedge clk);
        wr(GA, FRZ);
        rd(a_cnt(1), rv); chk("R6 frozen counter", rv, 32'h0);
        rd(a_cnt(2), rv); chk("R6 free counter", rv, 32'h4);

        // R7: global freeze holds counters
        wr(a_cnt(2), 32'h55);
        rd(a_cnt(0), rv);
        repeat (5) @(negedge clk);
        begin
            logic [31:0] c0;
            rd(a_cnt(0), c0); chk("R7 cycle counter held", c0, rv);
        end
        rd(a_cnt(2), rv); chk("R7 event counter held", rv, 32'h55);

        // R8: a write on an incrementing edge wins
        wr(GA, 32'h0);
        wr(a_cnt(2), 32'h100);
        repeat (2) @(negedge clk);
        wr(GA, FRZ);
        rd(a_cnt(2), rv); chk("R8 write beats increment", rv, 32'h103);

        // R9: no trip when the counter's condition enable is 0
        wr(a_ctl(5), lw(0, 0, 0));
        wr(a_cnt(5), 32'h7FFF_FFFF);
        wr(GA, 32'h6000_0000);
        repeat (2) @(negedge clk);
        rd(GA, rv); chk("R9 no freeze without enable", rv, 32'h6000_0000);
        chk("R9 no irq without enable", {31'b0, irq_o}, 32'h0);
        wr(GA, 32'hE000_0000);
        rd(a_cnt(5), rv); chk("R9 disabled counter ran", rv, 32'h8000_0002);
        wr(GA, FRZ);

        // R9: trip freezes everything
        wr(a_ctl(3), lw(0, 1, 0));
        wr(a_ctl(4), lw(0, 0, 0));
        wr(a_cnt(3), 32'h7FFF_FFFE);
        wr(a_cnt(4), 32'h0);
        wr(GA, 32'h6000_0000);
        repeat (4) @(negedge clk);
        rd(GA, rv);       chk("R9 hardware freeze", rv, 32'hE000_0000);
        chk("R9 irq", {31'b0, irq_o}, 32'h1);
        rd(a_cnt(3), rv); chk("R9 overflowing counter", rv, 32'h8000_0000);
        rd(a_cnt(4), rv); chk("R9 neighbour stopped", rv, 32'h2);

        // R10: release sequence
        wr(a_cnt(3), 32'h0);
        @(negedge clk);
        chk("R10 irq held while frozen", {31'b0, irq_o}, 32'h1);
        wr(GA, 32'h0);
        @(negedge clk);
        chk("R10 irq released", {31'b0, irq_o}, 32'h0);
        wr(GA, FRZ);

        // R11: hardware freeze against a same-edge software write
        wr(a_ctl(3), lw(0, 0, 0));
        wr(a_ctl(6), lw(0, 1, 0));
        wr(a_cnt(6), 32'h7FFF_FFFE);
        wr(GA, 32'h6000_0000);
        @(negedge clk);
        wr(GA, 32'h6000_0000);
        @(negedge clk);
        rd(GA, rv); chk("R11 freeze kept", rv, 32'hE000_0000);
        chk("R11 irq", {31'b0, irq_o}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule